// File: doc/BRIEF.md
# SPI Flash Page-Program Engine

This block is the slave side of a serial flash device, limited to writing one page at a time. A host on an SPI bus in mode 0 sends a one-byte opcode, a 24-bit address with the most significant byte first, and then any number of data bytes. The data lands in a 256-byte staging buffer. The buffer slot is the low address byte, and it advances with wrap-around inside the page. When chip select goes high, the block decides whether the transaction was well formed and allowed. If it was, a self-timed program cycle merges the staged bytes into a small on-chip array. Programming can only clear bits: each byte becomes old AND new.

Three commands are decoded: write enable, status read and page program. The status byte carries a busy flag, a write-enable latch and a program-error flag. The host polls this byte to learn when a program cycle has finished. A per-page protect input blocks programming of selected pages. A combinational observe port gives a direct view of the array contents.

All SPI pins are sampled in the system clock domain. The serial clock must therefore run several times slower than `clk`.

Top module: `spi_pgm_flash`

## Requirements
- R1: After reset the status byte reads 00h and every array byte reads FFh on the observe port.
- R2: Opcode 06h sets the write-enable latch (status bit 1) when chip select rises on a byte boundary, unless the block is busy.
- R3: Opcode 05h shifts out the live status byte, MSB first, changing on the falling SCK edge; bit 0 is busy, bit 1 is the write-enable latch, bit 5 is program error, and other bits are 0; the byte repeats while chip select stays low.
- R4: Opcode 02h is followed by three address bytes, most significant first, then data; the command is accepted only if the write-enable latch is 1 when the opcode arrives, and otherwise it is ignored with the array unchanged.
- R5: Data byte k goes to page slot (A[7:0] + k) mod 256, so writes wrap inside the addressed page.
- R6: When more than 256 data bytes are sent, only the last 256 are programmed.
- R7: Only slots that received data change, and each changed byte becomes old AND data.
- R8: A page program is aborted if chip select rises before the opcode, three address bytes and one data byte are complete, or if it rises off a multiple of eight bits. An abort leaves the array unchanged, clears the write-enable latch and does not set busy.
- R9: A page program that targets a page whose protect bit is 1 programs nothing, does not set busy and clears the write-enable latch.
- R10: An accepted program sets busy for BYTE_CYC cycles when exactly one data byte was sent and for PROG_CYC cycles otherwise; the write-enable latch is 0 from the first busy cycle.
- R11: Program error is set if any programmed byte differs from its data byte afterwards, and is cleared when the next program cycle starts.
- R12: Write-enable and page-program opcodes received while busy are ignored.
- R13: Address bits at and above ADDR_W are ignored, so the page is A[ADDR_W-1:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| prot | input | 2**(ADDR_W-8) | One protect bit per page |
| peek_addr | input | ADDR_W | Observe-port array address |
| peek_data | output | 8 | Observe-port array byte |

## Verification
A wrong slot pointer or a wrong kept-byte count shows on the observe port as soon as the program cycle ends. These bytes are either misplaced or left at FFh, and a sweep of the whole array against a bench-side model exposes them. A wrong latch or busy state shows on the next status poll. A missing latch clear reads 02h where 00h is expected. A wrong cycle length shows because busy is still set, or already clear, about one status byte after chip select rises.

// File: rtl/spi_pgm_pkg.sv
package spi_pgm_pkg;

  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  typedef enum logic [2:0] {
    C_NONE,
    C_WREN,
    C_RDSR,
    C_PROG,
    C_SKIP
  } cmd_e;

  // slot pointer advance with wrap inside the page
  function automatic logic [7:0] idx_step(input logic [7:0] i);
    return i + 8'd1;
  endfunction

  // a program pulse can only pull bits toward zero
  function automatic logic [7:0] burn(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  // true when the requested byte cannot be reached from the old contents
  function automatic logic verify_bad(input logic [7:0] old_v, input logic [7:0] new_v);
    return (old_v & new_v) != new_v;
  endfunction

  function automatic logic [7:0] status_pack(input logic busy, input logic wel,
                                             input logic err);
    return {2'b00, err, 3'b000, wel, busy};
  endfunction

endpackage

// File: rtl/spi_pgm_link.sv
module spi_pgm_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       tx_on,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic [7:0] rx_byte,
  output logic       rx_vld,
  output logic       cs_start,
  output logic       cs_end,
  output logic       on_boundary
);

  logic       sck_s, sck_q, cs_s, cs_q, mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] sr;
  logic [7:0] tx_sr;
  logic       sel, sck_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= 1'b0;
      sck_q  <= 1'b0;
      cs_s   <= 1'b1;
      cs_q   <= 1'b1;
      mosi_s <= 1'b0;
    end else begin
      sck_s  <= sck;
      sck_q  <= sck_s;
      cs_s   <= cs_n;
      cs_q   <= cs_s;
      mosi_s <= mosi;
    end
  end

  assign sel       = ~cs_s;
  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;
  assign cs_start  = ~cs_s & cs_q;
  assign cs_end    = cs_s & ~cs_q;

  assign rx_vld      = sel && sck_rise && (bit_cnt == 3'd7);
  assign rx_byte     = {sr, mosi_s};
  assign on_boundary = (bit_cnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= 3'd0;
      sr      <= 7'd0;
    end else if (!sel) begin
      bit_cnt <= 3'd0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      sr      <= {sr[5:0], mosi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= 8'd0;
    end else if (!sel) begin
      tx_sr <= 8'd0;
    end else if (sck_fall) begin
      if (on_boundary && tx_on) tx_sr <= tx_byte;
      else                      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

  assign miso = tx_sr[7];

  // R3
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso);

endmodule

// File: rtl/spi_pgm_page_buf.sv
module spi_pgm_page_buf #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spi_pgm_array.sv
module spi_pgm_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata     = mem[raddr];
  assign peek_data = mem[peek_addr];

endmodule

// File: rtl/spi_pgm_flash.sv
module spi_pgm_flash
  import spi_pgm_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PROG_CYC = 300,
  parameter int BYTE_CYC = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sck,
  input  logic                       cs_n,
  input  logic                       mosi,
  output logic                       miso,
  input  logic [(1<<(ADDR_W-8))-1:0] prot,
  input  logic [ADDR_W-1:0]          peek_addr,
  output logic [7:0]                 peek_data
);

  localparam int PAGE_W = ADDR_W - 8;
  localparam int TMR_W  = $clog2(PROG_CYC + 1);

  // link events
  logic [7:0] rx_byte;
  logic       rx_vld, cs_start, cs_end, on_boundary;

  // command state
  cmd_e              cmd;
  logic [2:0]        nbytes;
  logic [PAGE_W-1:0] page_r;
  logic [7:0]        ptr, start_idx;
  logic [8:0]        dcnt;
  logic              wel, epe;

  // program cycle state
  logic [TMR_W-1:0]  timer;
  logic              walking;
  logic [7:0]        wptr;
  logic [8:0]        wleft;
  logic [PAGE_W-1:0] prog_page;

  // named events
  logic       busy, pgm_go, buf_we, tx_on;
  logic [7:0] status, buf_q, arr_old;

  assign busy   = (timer != '0);
  assign tx_on  = (cmd == C_RDSR);
  assign status = status_pack(busy, wel, epe);
  assign buf_we = rx_vld && (cmd == C_PROG) && (nbytes >= 3'd4);
  assign pgm_go = cs_end && (cmd == C_PROG) && (nbytes == 3'd5) && on_boundary &&
                  !prot[page_r];

  spi_pgm_link u_link (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_on(tx_on), .tx_byte(status), .miso(miso),
    .rx_byte(rx_byte), .rx_vld(rx_vld), .cs_start(cs_start), .cs_end(cs_end),
    .on_boundary(on_boundary)
  );

  spi_pgm_page_buf #(.IDX_W(8)) u_buf (
    .clk(clk), .we(buf_we), .waddr(ptr), .wdata(rx_byte),
    .raddr(wptr), .rdata(buf_q)
  );

  spi_pgm_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(walking),
    .waddr({prog_page, wptr}), .wdata(burn(arr_old, buf_q)),
    .raddr({prog_page, wptr}), .rdata(arr_old),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  // opcode decode and byte position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= C_NONE;
      nbytes <= 3'd0;
    end else if (cs_start || cs_end) begin
      cmd    <= C_NONE;
      nbytes <= 3'd0;
    end else if (rx_vld) begin
      if (nbytes != 3'd5) nbytes <= nbytes + 3'd1;
      if (nbytes == 3'd0) begin
        unique case (rx_byte)
          OP_WREN: cmd <= busy ? C_SKIP : C_WREN;
          OP_RDSR: cmd <= C_RDSR;
          OP_PROG: cmd <= (wel && !busy) ? C_PROG : C_SKIP;
          default: cmd <= C_SKIP;
        endcase
      end
    end
  end

  // address capture and buffer slot pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_r    <= '0;
      ptr       <= 8'd0;
      start_idx <= 8'd0;
      dcnt      <= 9'd0;
    end else if (cs_start) begin
      dcnt <= 9'd0;
    end else if (rx_vld && cmd == C_PROG) begin
      if (nbytes == 3'd2) page_r <= rx_byte[PAGE_W-1:0];
      if (nbytes == 3'd3) begin
        ptr       <= rx_byte;
        start_idx <= rx_byte;
      end
      if (buf_we) begin
        ptr <= idx_step(ptr);
        if (dcnt != 9'd256) dcnt <= dcnt + 9'd1;
      end
    end
  end

  // write-enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      wel <= 1'b0;
    else if (cs_end && cmd == C_WREN && on_boundary) wel <= 1'b1;
    else if (cs_end && cmd == C_PROG)                wel <= 1'b0;
  end

  // self-timed cycle and buffer walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer     <= '0;
      walking   <= 1'b0;
      wptr      <= 8'd0;
      wleft     <= 9'd0;
      prog_page <= '0;
      epe       <= 1'b0;
    end else if (pgm_go) begin
      timer     <= (dcnt == 9'd1) ? TMR_W'(BYTE_CYC) : TMR_W'(PROG_CYC);
      walking   <= 1'b1;
      wptr      <= start_idx;
      wleft     <= dcnt;
      prog_page <= page_r;
      epe       <= 1'b0;
    end else begin
      if (busy) timer <= timer - 1'b1;
      if (walking) begin
        if (verify_bad(arr_old, buf_q)) epe <= 1'b1;
        wptr  <= idx_step(wptr);
        wleft <= wleft - 9'd1;
        if (wleft == 9'd1) walking <= 1'b0;
      end
    end
  end

  // R10
  walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> busy);

  // R10
  go_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |=> (busy && !wel));

  // R12
  wel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !busy);

  // R11
  epe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_go |=> !epe);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_end));

endmodule

// File: tb/test_spi_pgm_flash.sv
`timescale 1ns/1ps
module test_spi_pgm_flash;

  localparam int AW    = 10;
  localparam int PCYC  = 300;
  localparam int BCYC  = 20;
  localparam int NLOC  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0;
  logic          cs_n = 1'b1;
  logic          mosi = 1'b0;
  logic          miso;
  logic [3:0]    prot = 4'b0100;
  logic [AW-1:0] peek_addr = '0;
  logic [7:0]    peek_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] model [NLOC];
  logic [7:0] dq [300];

  always #4 clk = ~clk;

  spi_pgm_flash #(.ADDR_W(AW), .PROG_CYC(PCYC), .BYTE_CYC(BCYC)) i_spi_pgm_flash (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .prot(prot), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string req, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(4);
      rx[i] = miso;
      sck = 1'b1;
      tick(8);
      sck = 1'b0;
      tick(4);
    end
  endtask

  task automatic bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = v[7-i];
      tick(4);
      sck = 1'b1;
      tick(8);
      sck = 1'b0;
      tick(4);
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(8);
  endtask

  task automatic cs_hi();
    tick(8);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo();
    xfer(8'h05, d);
    xfer(8'h00, s);
    cs_hi();
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo();
    xfer(8'h06, d);
    cs_hi();
  endtask

  // opcode, address and n data bytes from dq, chip select raised after
  task automatic pp(input logic [23:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xfer(8'h02, d);
    xfer(a[23:16], d);
    xfer(a[15:8], d);
    xfer(a[7:0], d);
    for (int k = 0; k < n; k++) xfer(dq[k], d);
    cs_hi();
  endtask

  // bench-side expectation: last 256 bytes, slot (low + k) mod 256, AND merge
  task automatic model_apply(input logic [23:0] a, input int n, output logic err);
    int first;
    int loc;
    logic [7:0] old;
    first = (n > 256) ? n - 256 : 0;
    err = 1'b0;
    for (int k = first; k < n; k++) begin
      loc = int'(a[AW-1:8]) * 256 + ((int'(a[7:0]) + k) % 256);
      old = model[loc];
      if ((old & dq[k]) != dq[k]) err = 1'b1;
      model[loc] = old & dq[k];
    end
  endtask

  task automatic peek(input int loc, output logic [7:0] v);
    peek_addr = AW'(loc);
    tick(1);
    v = peek_data;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2, v, d;
    logic err;
    for (int i = 0; i < NLOC; i++) model[i] = 8'hFF;
    tick(20);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    rdsr(s);
    chk8("R1", "status after reset", s, 8'h00);
    peek(0, v);     chk8("R1", "array[000]", v, 8'hFF);
    peek(1023, v);  chk8("R1", "array[3FF]", v, 8'hFF);

    // R4 program without latch is ignored
    dq[0] = 8'h12;
    pp(24'h000010, 1);
    rdsr(s);
    chk8("R4", "status no latch", s, 8'h00);
    peek(16'h010, v); chk8("R4", "array[010] untouched", v, 8'hFF);

    // R2 R3 latch set, status repeats
    wren();
    cs_lo();
    xfer(8'h05, d);
    xfer(8'h00, s);
    xfer(8'h00, s2);
    cs_hi();
    chk8("R2", "status after wren", s, 8'h02);
    chk8("R3", "repeated status", s2, 8'h02);

    // R5 R10 wrap across page end, busy during multi-byte cycle
    dq[0] = 8'hAA; dq[1] = 8'h55; dq[2] = 8'h0F;
    pp(24'h0000FE, 3);
    model_apply(24'h0000FE, 3, err);
    rdsr(s);
    chk8("R10", "status during multi-byte cycle", s, 8'h01);
    tick(PCYC);
    rdsr(s);
    chk8("R10", "status after cycle", s, 8'h00);
    peek(16'h0FE, v); chk8("R5", "array[0FE]", v, 8'hAA);
    peek(16'h0FF, v); chk8("R5", "array[0FF]", v, 8'h55);
    peek(16'h000, v); chk8("R5", "array[000] wrapped", v, 8'h0F);
    peek(16'h001, v); chk8("R7", "array[001] untouched", v, 8'hFF);

    // R10 single byte uses the short cycle
    wren();
    dq[0] = 8'h5A;
    pp(24'h000040, 1);
    model_apply(24'h000040, 1, err);
    rdsr(s);
    chk8("R10", "single byte cycle already done", s, 8'h00);

    // R6 more than a page of data
    for (int k = 0; k < 260; k++) dq[k] = 8'((k * 7 + 3) & 255);
    wren();
    pp(24'h000110, 260);
    model_apply(24'h000110, 260, err);
    tick(PCYC + 20);
    peek(16'h110, v); chk8("R6", "array[110] holds byte 256", v, 8'((256 * 7 + 3) & 255));
    peek(16'h10F, v); chk8("R6", "array[10F] holds byte 255", v, 8'((255 * 7 + 3) & 255));

    // R7 R11 AND merge and program error
    wren();
    dq[0] = 8'hF0;
    pp(24'h000002, 1);
    model_apply(24'h000002, 1, err);
    tick(BCYC + 20);
    rdsr(s);
    chk8("R11", "no error on erased byte", s, 8'h00);
    wren();
    dq[0] = 8'h0F;
    pp(24'h000002, 1);
    model_apply(24'h000002, 1, err);
    tick(BCYC + 20);
    rdsr(s);
    chk8("R11", "error flag set", s, {2'b00, err, 5'b00000});
    peek(16'h002, v); chk8("R7", "array[002] AND merge", v, 8'h00);
    wren();
    dq[0] = 8'h00;
    pp(24'h000003, 1);
    model_apply(24'h000003, 1, err);
    tick(BCYC + 20);
    rdsr(s);
    chk8("R11", "error flag cleared by next cycle", s, 8'h00);

    // R8 aborts
    wren();
    cs_lo();
    xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d);
    cs_hi();
    rdsr(s);
    chk8("R8", "short address", s, 8'h00);

    wren();
    cs_lo();
    xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h30, d);
    bits(8'h00, 3);
    cs_hi();
    rdsr(s);
    chk8("R8", "partial first data byte", s, 8'h00);
    peek(16'h030, v); chk8("R8", "array[030] after partial", v, 8'hFF);

    wren();
    cs_lo();
    xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h31, d);
    xfer(8'h44, d);
    bits(8'h00, 5);
    cs_hi();
    tick(BCYC + 20);
    rdsr(s);
    chk8("R8", "misaligned after data", s, 8'h00);
    peek(16'h031, v); chk8("R8", "array[031] after misaligned", v, 8'hFF);

    wren();
    cs_lo();
    xfer(8'h02, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h32, d);
    cs_hi();
    rdsr(s);
    chk8("R8", "address without data", s, 8'h00);

    // R9 protected page 2
    wren();
    dq[0] = 8'h00; dq[1] = 8'h00;
    pp(24'h000205, 2);
    rdsr(s);
    chk8("R9", "protected: no busy, latch cleared", s, 8'h00);
    peek(16'h205, v); chk8("R9", "array[205] protected", v, 8'hFF);

    // R12 write enable ignored while busy
    wren();
    dq[0] = 8'h11; dq[1] = 8'h22;
    pp(24'h000300, 2);
    model_apply(24'h000300, 2, err);
    wren();
    rdsr(s);
    chk8("R12", "wren during busy ignored", s, 8'h01);
    tick(PCYC);
    rdsr(s);
    chk8("R12", "latch still clear after cycle", s, 8'h00);

    // R13 high address bits ignored
    wren();
    dq[0] = 8'h99;
    pp(24'hAB0380, 1);
    model_apply(24'hAB0380, 1, err);
    tick(BCYC + 20);
    peek(16'h380, v); chk8("R13", "array[380] via aliased address", v, 8'h99);

    // R7 full sweep against model
    for (int i = 0; i < NLOC; i++) begin
      peek(i, v);
      chk8("R7", $sformatf("sweep array[%03h]", i), v, model[i]);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule